// File: doc/BRIEF.md
# Wormhole Thread Packet Router

This block moves migrating thread contexts between the cores of a cluster. Every core, and one extra port that serves as thread storage, has a source stream (words leaving that port's output queue) and a sink stream (words entering its input queue). A thread travels as one packet of variable length. The packet opens with a header word that names the destination port and carries the thread identifier of the migration hardware. Any number of payload words follow, and a tail word closes the packet.

A single lock covers the whole router. When the router is idle, the headers waiting at the sources are arbitrated in round-robin order, and the winner owns the lock. Its words then stream one per cycle to the destination sink. The lock is released only when that packet's tail is accepted. Backpressure at the destination stalls the locked path and loses no word. A packet whose header names a port that does not exist is drained through its tail without being forwarded, and an error pulse is raised. An optional register stage can sit in the shared channel.

Top module: `thread_wormhole_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no sink is valid, no source is ready and `route_err` is low.
- R2: Word kinds are encoded on the 2-bit kind field as 01 for a header, 00 for a payload word and 10 for a tail. Header bits [7:0] hold the destination port. Port numbers 0 to NUM_CORES-1 are cores and port NUM_CORES is thread storage. The header is forwarded unchanged, including the thread identifier in bits [23:8], and it goes only to the named sink.
- R3: Every word of a forwarded packet reaches its destination sink unchanged and in the order it was sent. The router moves one word per cycle when no stall occurs.
- R4: Once a header has been accepted, no other source is accepted until that packet's tail has been accepted.
- R5: When the router is idle, the first source holding a header at or after the round-robin pointer wins. The pointer starts at 0 after reset and is set to the port after the owner when the owner's tail is accepted, wrapping from NUM_CORES to 0.
- R6: With the channel stage enabled, a sink that is valid while its ready is low stays valid with its word unchanged in the next cycle.
- R7: A header whose destination field is NUM_CORES+1 or more is accepted. Its packet is consumed through the tail and nothing of it appears at any sink. `route_err` is high for exactly the one cycle after that header was accepted.
- R8: While the router is idle, a source that presents a word that is not a header is not accepted and produces nothing at any sink.
- R9: With the channel stage enabled, a word accepted from a source appears at its sink one cycle later. Without the stage it appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | NUM_CORES+1 | Source word valid, one bit per port |
| src_data | input | (NUM_CORES+1)*DATA_W | Source words, port p at bits [p*DATA_W +: DATA_W] |
| src_kind | input | (NUM_CORES+1)*2 | Source word kinds, port p at bits [p*2 +: 2] |
| src_ready | output | NUM_CORES+1 | Source word accepted this cycle when also valid |
| dst_valid | output | NUM_CORES+1 | Sink word valid, one bit per port |
| dst_data | output | (NUM_CORES+1)*DATA_W | Sink words, port p at bits [p*DATA_W +: DATA_W] |
| dst_kind | output | (NUM_CORES+1)*2 | Sink word kinds, port p at bits [p*2 +: 2] |
| dst_ready | input | NUM_CORES+1 | Sink can take a word |
| route_err | output | 1 | One-cycle pulse after a header with a bad destination is accepted |

## Verification
The case that matters most is a tail being accepted from the owner while headers already wait at other sources. In that cycle the lock is released, the pointer moves, and the following cycle grants a new owner. Stalled sinks may also still hold words of the finished packet at that point. The bench provokes this by loading several sources in the same cycle, with random sink readiness and random gaps between source words. It judges the result from the order in which headers are granted, from a check that no second source is accepted while a packet is open, and from a per-sink scoreboard of every accepted word.

// File: rtl/thr_rt_pkg.sv
package thr_rt_pkg;
   typedef enum logic [1:0] {
      WK_BODY = 2'b00,
      WK_HEAD = 2'b01,
      WK_TAIL = 2'b10
   } word_kind_e;

   localparam int HDR_DEST_W = 8;
   localparam int TID_LSB    = 8;
   localparam int TID_W      = 16;
endpackage

// File: rtl/thr_rt_rr_arb.sv
module thr_rt_rr_arb #(
   parameter int N  = 5,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic          any,
   output logic [IW-1:0] win
);
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = int'(ptr) + k;
         if (j >= N) j = j - N;
         if (!any && req[j]) begin
            any = 1'b1;
            win = IW'(j);
         end
      end
   end
endmodule

// File: rtl/thr_rt_stage.sv
module thr_rt_stage #(
   parameter int W    = 8,
   parameter int PIPE = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   input  logic [W-1:0] up_payload,
   output logic         up_ready,
   output logic         dn_valid,
   output logic [W-1:0] dn_payload,
   input  logic         dn_ready
);
   if (PIPE == 1) begin : g_reg
      logic         v_q;
      logic [W-1:0] p_q;

      assign up_ready   = !v_q || dn_ready;
      assign dn_valid   = v_q;
      assign dn_payload = p_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            p_q <= '0;
         end else if (up_ready) begin
            v_q <= up_valid;
            if (up_valid) p_q <= up_payload;
         end
      end
   end else begin : g_wire
      assign up_ready   = dn_ready;
      assign dn_valid   = up_valid;
      assign dn_payload = up_payload;
   end
endmodule

// File: rtl/thread_wormhole_router.sv
module thread_wormhole_router
   import thr_rt_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int DATA_W    = 64,
   parameter int PIPE      = 1,
   localparam int NPORT    = NUM_CORES + 1,
   localparam int IW       = $clog2(NPORT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        src_valid,
   input  logic [NPORT*DATA_W-1:0] src_data,
   input  logic [NPORT*2-1:0]      src_kind,
   output logic [NPORT-1:0]        src_ready,
   output logic [NPORT-1:0]        dst_valid,
   output logic [NPORT*DATA_W-1:0] dst_data,
   output logic [NPORT*2-1:0]      dst_kind,
   input  logic [NPORT-1:0]        dst_ready,
   output logic                    route_err
);
   localparam int PW = IW + 2 + DATA_W;

   if (NUM_CORES < 1) begin : g_bad_cores
      $error("thread_wormhole_router: NUM_CORES must be at least 1");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_bad_pipe
      $error("thread_wormhole_router: PIPE must be 0 or 1");
   end
   if (DATA_W < TID_LSB + TID_W) begin : g_bad_width
      $error("thread_wormhole_router: DATA_W too narrow for the header");
   end
   if (NPORT > (1 << HDR_DEST_W)) begin : g_bad_ports
      $error("thread_wormhole_router: too many ports for the destination field");
   end

   // per-port views of the flat source buses
   logic [DATA_W-1:0] s_data [NPORT];
   logic [1:0]        s_kind [NPORT];
   logic [NPORT-1:0]  head_req;

   for (genvar i = 0; i < NPORT; i++) begin : g_src
      assign s_data[i]   = src_data[i*DATA_W +: DATA_W];
      assign s_kind[i]   = src_kind[i*2 +: 2];
      assign head_req[i] = src_valid[i] && (s_kind[i] == WK_HEAD);
   end

   // lock state
   logic          locked_q, drop_q, err_q;
   logic [IW-1:0] owner_q, dest_q, ptr_q;

   logic          arb_any;
   logic [IW-1:0] arb_win;

   thr_rt_rr_arb #(.N(NPORT)) u_arb (
      .req (head_req),
      .ptr (ptr_q),
      .any (arb_any),
      .win (arb_win)
   );

   logic [IW-1:0]         sel;
   logic                  cur_valid;
   logic [DATA_W-1:0]     cur_data;
   logic [1:0]            cur_kind;
   logic [HDR_DEST_W-1:0] hdr_field;
   logic                  hdr_bad;
   logic [IW-1:0]         cur_dest;
   logic                  cur_drop;
   logic                  take;
   logic                  st_up_ready;

   assign sel       = locked_q ? owner_q : arb_win;
   assign cur_valid = locked_q ? src_valid[sel] : arb_any;
   assign cur_data  = s_data[sel];
   assign cur_kind  = s_kind[sel];
   assign hdr_field = cur_data[HDR_DEST_W-1:0];
   assign hdr_bad   = (hdr_field >= HDR_DEST_W'(NPORT));
   assign cur_dest  = locked_q ? dest_q : hdr_field[IW-1:0];
   assign cur_drop  = locked_q ? drop_q : hdr_bad;
   assign take      = cur_valid && (cur_drop || st_up_ready);

   for (genvar i = 0; i < NPORT; i++) begin : g_rdy
      assign src_ready[i] = take && (sel == IW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         drop_q   <= 1'b0;
         err_q    <= 1'b0;
         owner_q  <= '0;
         dest_q   <= '0;
         ptr_q    <= '0;
      end else begin
         err_q <= take && !locked_q && hdr_bad;
         if (take) begin
            if (!locked_q) begin
               locked_q <= 1'b1;
               owner_q  <= arb_win;
               dest_q   <= hdr_field[IW-1:0];
               drop_q   <= hdr_bad;
            end else if (cur_kind == WK_TAIL) begin
               locked_q <= 1'b0;
               drop_q   <= 1'b0;
               ptr_q    <= (owner_q == IW'(NPORT - 1)) ? '0 : IW'(owner_q + IW'(1));
            end
         end
      end
   end

   assign route_err = err_q;

   // shared channel, optionally registered
   logic          ch_valid, ch_ready;
   logic [PW-1:0] ch_payload;
   logic [IW-1:0] ch_dest;
   logic [1:0]    ch_kind;
   logic [DATA_W-1:0] ch_data;

   thr_rt_stage #(.W(PW), .PIPE(PIPE)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_valid   (cur_valid && !cur_drop),
      .up_payload ({cur_dest, cur_kind, cur_data}),
      .up_ready   (st_up_ready),
      .dn_valid   (ch_valid),
      .dn_payload (ch_payload),
      .dn_ready   (ch_ready)
   );

   assign {ch_dest, ch_kind, ch_data} = ch_payload;

   always_comb begin
      ch_ready = 1'b0;
      for (int d = 0; d < NPORT; d++) begin
         if (ch_dest == IW'(d)) ch_ready = dst_ready[d];
      end
   end

   for (genvar d = 0; d < NPORT; d++) begin : g_dst
      assign dst_valid[d]                = ch_valid && (ch_dest == IW'(d));
      assign dst_data[d*DATA_W +: DATA_W] = ch_data;
      assign dst_kind[d*2 +: 2]           = ch_kind;
   end
endmodule

// File: rtl/thr_rt_checker.sv
module thr_rt_checker
   import thr_rt_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int DATA_W    = 64,
   parameter int PIPE      = 1,
   localparam int NPORT    = NUM_CORES + 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPORT-1:0]        src_valid,
   input logic [NPORT*DATA_W-1:0] src_data,
   input logic [NPORT*2-1:0]      src_kind,
   input logic [NPORT-1:0]        src_ready,
   input logic [NPORT-1:0]        dst_valid,
   input logic [NPORT*DATA_W-1:0] dst_data,
   input logic [NPORT*2-1:0]      dst_kind,
   input logic [NPORT-1:0]        dst_ready,
   input logic                    route_err
);
   logic [NPORT-1:0]  fire;
   logic [DATA_W-1:0] acc_data, out_data;
   logic [1:0]        acc_kind, out_kind;
   logic              any_fire, hdr_fire, bad_fire, tail_fire, dropped_now;
   logic              in_pkt_q, drop_trk_q;
   logic [NPORT-1:0]  own_q;

   always_comb begin
      fire     = src_valid & src_ready;
      acc_data = '0;
      acc_kind = '0;
      out_data = '0;
      out_kind = '0;
      for (int i = 0; i < NPORT; i++) begin
         if (fire[i]) begin
            acc_data = acc_data | src_data[i*DATA_W +: DATA_W];
            acc_kind = acc_kind | src_kind[i*2 +: 2];
         end
         if (dst_valid[i]) begin
            out_data = out_data | dst_data[i*DATA_W +: DATA_W];
            out_kind = out_kind | dst_kind[i*2 +: 2];
         end
      end
   end

   assign any_fire    = |fire;
   assign hdr_fire    = any_fire && !in_pkt_q;
   assign bad_fire    = hdr_fire && (acc_data[HDR_DEST_W-1:0] >= HDR_DEST_W'(NPORT));
   assign tail_fire   = any_fire && in_pkt_q && (acc_kind == WK_TAIL);
   assign dropped_now = hdr_fire ? bad_fire : drop_trk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt_q   <= 1'b0;
         drop_trk_q <= 1'b0;
         own_q      <= '0;
      end else if (hdr_fire) begin
         in_pkt_q   <= 1'b1;
         drop_trk_q <= bad_fire;
         own_q      <= fire;
      end else if (tail_fire) begin
         in_pkt_q   <= 1'b0;
         drop_trk_q <= 1'b0;
         own_q      <= '0;
      end
   end

   p_single_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ready));

   p_owner_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_pkt_q |-> ((src_ready & ~own_q) == '0));

   p_single_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dst_valid));

   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bad_fire |=> route_err);

   p_err_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      route_err |-> $past(bad_fire));

   for (genvar d = 0; d < NPORT; d++) begin : g_port
      p_hdr_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (dst_valid[d] && dst_kind[d*2 +: 2] == WK_HEAD)
            |-> (dst_data[d*DATA_W +: HDR_DEST_W] == HDR_DEST_W'(d)));

      if (PIPE == 1) begin : g_hold
         p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_valid[d] && !dst_ready[d])
               |=> (dst_valid[d] && $stable(dst_data[d*DATA_W +: DATA_W])
                    && $stable(dst_kind[d*2 +: 2])));
      end
   end

   if (PIPE == 1) begin : g_pass
      p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (any_fire && !dropped_now)
            |=> ((|dst_valid) && out_data == $past(acc_data)
                 && out_kind == $past(acc_kind)));
   end
endmodule

bind thread_wormhole_router thr_rt_checker #(
   .NUM_CORES (NUM_CORES),
   .DATA_W    (DATA_W),
   .PIPE      (PIPE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_data  (src_data),
   .src_kind  (src_kind),
   .src_ready (src_ready),
   .dst_valid (dst_valid),
   .dst_data  (dst_data),
   .dst_kind  (dst_kind),
   .dst_ready (dst_ready),
   .route_err (route_err)
);

// File: tb/thread_wormhole_router_bench.sv
`timescale 1ns/1ps
module thread_wormhole_router_bench;
   localparam int NC   = 4;
   localparam int NP   = NC + 1;
   localparam int DW   = 64;
   localparam int PIPE = 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NP-1:0]     src_valid;
   logic [NP*DW-1:0]  src_data;
   logic [NP*2-1:0]   src_kind;
   logic [NP-1:0]     src_ready;
   logic [NP-1:0]     dst_valid;
   logic [NP*DW-1:0]  dst_data;
   logic [NP*2-1:0]   dst_kind;
   logic [NP-1:0]     dst_ready;
   logic              route_err;

   always #2.5 clk = ~clk;

   thread_wormhole_router #(.NUM_CORES(NC), .DATA_W(DW), .PIPE(PIPE)) u_thread_wormhole_router (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_data(src_data), .src_kind(src_kind), .src_ready(src_ready),
      .dst_valid(dst_valid), .dst_data(dst_data), .dst_kind(dst_kind), .dst_ready(dst_ready),
      .route_err(route_err)
   );

   logic [65:0] srcq [NP][$];
   logic [65:0] expq [NP][$];
   int          grant_log [$];
   int          pkt_dest [NP];
   bit          open_f [NP];
   bit          drop_f [NP];
   bit          held_v [NP];
   logic [65:0] held_w [NP];
   logic [NP-1:0] fire_q;
   int n_chk, n_fail, cyc, lock_viol, err_seen, hdr_fire_cyc;
   bit err_exp, bub_en, lat_chk;
   int unsigned rdy_pct;

   task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic add_pkt(input int s, input int dest, input int nbody, input logic [15:0] tid);
      logic [63:0] w;
      w = {$urandom(), $urandom()};
      w[7:0]  = 8'(dest);
      w[23:8] = tid;
      srcq[s].push_back({2'b01, w});
      for (int b = 0; b < nbody; b++) srcq[s].push_back({2'b00, $urandom(), $urandom()});
      srcq[s].push_back({2'b10, $urandom(), $urandom()});
   endtask

   task automatic mon();
      logic [NP-1:0] fire;
      logic [65:0]   w;
      bit            bad_now;
      cyc++;
      bad_now = 1'b0;
      fire = src_valid & src_ready;
      for (int i = 0; i < NP; i++) begin
         if (fire[i]) begin
            w = {src_kind[i*2 +: 2], src_data[i*DW +: DW]};
            for (int j = 0; j < NP; j++) if (j != i && open_f[j]) lock_viol++;
            if (!open_f[i]) begin
               open_f[i]   = 1'b1;
               pkt_dest[i] = int'(w[7:0]);
               drop_f[i]   = (int'(w[7:0]) >= NP);
               grant_log.push_back(i);
               hdr_fire_cyc = cyc;
               if (drop_f[i]) bad_now = 1'b1;
            end
            if (!drop_f[i]) expq[pkt_dest[i]].push_back(w);
            if (w[65:64] == 2'b10) open_f[i] = 1'b0;
         end
      end
      if (route_err || err_exp) chk(route_err == err_exp, "R7 error pulse", 66'(route_err), 66'(err_exp));
      if (route_err) err_seen++;
      err_exp = bad_now;
      for (int d = 0; d < NP; d++) begin
         w = {dst_kind[d*2 +: 2], dst_data[d*DW +: DW]};
         if (held_v[d]) chk(dst_valid[d] && w == held_w[d], "R6 stalled word held", w, held_w[d]);
         held_v[d] = 1'b0;
         if (dst_valid[d] && dst_ready[d]) begin
            if (expq[d].size() == 0) chk(1'b0, "R3 unexpected word", w, '0);
            else begin
               logic [65:0] e;
               e = expq[d].pop_front();
               chk(w == e, "R3 word order and data", w, e);
            end
            if (w[65:64] == 2'b01) begin
               chk(int'(w[7:0]) == d, "R2 header port", 66'(w[7:0]), 66'(d));
               if (lat_chk) chk(cyc - hdr_fire_cyc == PIPE, "R9 latency", 66'(cyc - hdr_fire_cyc), 66'(PIPE));
            end
         end else if (dst_valid[d]) begin
            held_v[d] = 1'b1;
            held_w[d] = w;
         end
      end
      fire_q = fire;
   endtask

   task automatic drv();
      for (int i = 0; i < NP; i++) begin
         if (fire_q[i]) begin
            void'(srcq[i].pop_front());
            src_valid[i] = 1'b0;
         end
         if (!src_valid[i] && srcq[i].size() > 0 && (!bub_en || $urandom_range(3) != 0)) begin
            src_valid[i]            = 1'b1;
            src_data[i*DW +: DW]    = srcq[i][0][63:0];
            src_kind[i*2 +: 2]      = srcq[i][0][65:64];
         end
      end
      for (int d = 0; d < NP; d++) dst_ready[d] = ($urandom_range(99) < rdy_pct);
   endtask

   task automatic run(input int n);
      repeat (n) begin
         @(negedge clk);
         mon();
         @(posedge clk);
         #1;
         drv();
      end
   endtask

   function automatic bit idle_all();
      bit r;
      r = (src_valid == '0) && (dst_valid == '0);
      for (int i = 0; i < NP; i++) if (srcq[i].size() != 0 || expq[i].size() != 0) r = 1'b0;
      return r;
   endfunction

   task automatic drain(input int maxc);
      int c;
      c = 0;
      run(2);
      while (!idle_all() && c < maxc) begin
         run(1);
         c++;
      end
      if (c >= maxc) chk(1'b0, "R3 drain timeout", 66'(c), 66'(maxc));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0; src_valid = '0; src_data = '0; src_kind = '0; dst_ready = '0;
      fire_q = '0; rdy_pct = 100; bub_en = 1'b0; lat_chk = 1'b0; err_exp = 1'b0;
      for (int i = 0; i < NP; i++) begin open_f[i] = 0; drop_f[i] = 0; held_v[i] = 0; pkt_dest[i] = 0; end
      @(negedge clk);
      chk(dst_valid == '0 && src_ready == '0 && !route_err, "R1 state in reset", 66'(dst_valid), '0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      dst_ready = '1;
      @(negedge clk);
      chk(dst_valid == '0, "R1 sinks idle", 66'(dst_valid), '0);
      chk(src_ready == '0, "R1 sources idle", 66'(src_ready), '0);
      chk(!route_err, "R1 no error", 66'(route_err), '0);
      @(posedge clk); #1;

      // R8: payload word on an idle router is not taken
      src_valid[1] = 1'b1; src_kind[3:2] = 2'b00; src_data[DW +: DW] = 64'h1234;
      repeat (3) begin
         @(negedge clk);
         chk(src_ready[1] == 1'b0 && dst_valid == '0, "R8 stray payload ignored", 66'({src_ready, dst_valid}), '0);
         @(posedge clk); #1;
      end
      src_valid[1] = 1'b0;

      // R9 and R2: header to the storage port, latency checked
      lat_chk = 1'b1;
      add_pkt(0, NC, 0, 16'hA5A5);
      drain(200);
      lat_chk = 1'b0;

      // R5: pointer moves past the owner
      add_pkt(2, 1, 1, 16'h0002);
      drain(200);
      grant_log.delete();
      add_pkt(0, 3, 2, 16'h0010); add_pkt(1, 2, 1, 16'h0011); add_pkt(3, 0, 0, 16'h0013);
      drain(400);
      chk(grant_log.size() == 3, "R5 grant count", 66'(grant_log.size()), 66'(3));
      if (grant_log.size() == 3) begin
         chk(grant_log[0] == 3, "R5 first grant", 66'(grant_log[0]), 66'(3));
         chk(grant_log[1] == 0, "R5 second grant", 66'(grant_log[1]), 66'(0));
         chk(grant_log[2] == 1, "R5 third grant", 66'(grant_log[2]), 66'(1));
      end
      grant_log.delete();
      add_pkt(1, 4, 0, 16'h0021); add_pkt(4, 2, 1, 16'h0024);
      drain(400);
      chk(grant_log.size() == 2 && grant_log[0] == 4 && grant_log[1] == 1, "R5 wrap order",
          66'(grant_log.size() == 2 ? grant_log[0] * 16 + grant_log[1] : 0), 66'(4 * 16 + 1));

      // R7: bad destination drained, next packet from same source still routed
      err_seen = 0;
      add_pkt(3, 9, 2, 16'h0BAD); add_pkt(3, 2, 0, 16'h0003);
      drain(400);
      chk(err_seen == 1, "R7 one error pulse", 66'(err_seen), 66'(1));

      // R6: heavy backpressure on a long packet
      rdy_pct = 30;
      add_pkt(2, 0, 6, 16'h0606);
      drain(2000);

      // random mix
      bub_en = 1'b1; rdy_pct = 70; err_seen = 0;
      for (int s = 0; s < NP; s++) begin
         for (int p = 0; p < 8; p++) begin
            int dest;
            dest = ($urandom_range(9) == 0) ? NP + int'($urandom_range(3)) : int'($urandom_range(NP - 1));
            add_pkt(s, dest, int'($urandom_range(5)), 16'($urandom()));
         end
      end
      drain(50000);

      chk(lock_viol == 0, "R4 no second source while packet open", 66'(lock_viol), '0);
      for (int d = 0; d < NP; d++) chk(expq[d].size() == 0, "R3 all words delivered", 66'(expq[d].size()), '0);
      summary();
      $finish;
   end
endmodule